// File: doc/BRIEF.md
# Asynchronous Strobe-Handshake Register Bus Slave

This block lets an external processor read and write a small on-chip register array over an asynchronous parallel bus. The bus has separate active-low read and write strobes, an active-low chip select, an address-latch-enable, and an active-low ready acknowledge. The bidirectional data bus is split into a data-in port, a data-out port and an output-enable, so that the pad ring can build the tristate driver.

All bus control inputs are resynchronised into the local clock domain through a configurable flop chain. The raw address passes through a pipeline of the same depth, so it stays aligned with the synchronised latch-enable. While the latch-enable is high, the internal address follows the bus. When the latch-enable falls, the address is frozen for the rest of the cycle. If the latch-enable is tied high, the path stays transparent and accesses still work.

A strobe's falling edge, seen while chip select is low, starts exactly one access. Ready is then pulled low for as long as the strobe and chip select stay asserted.

Top module: `cpu_regbus_slave`

## Requirements
- R1: After reset, ready (`bus_rdy_n`) is 1, the output-enable `bus_doe` is 0, and every implemented register reads back as 0x00.
- R2: While `bus_cs_n` is 1, no strobe starts an access: ready stays 1 and no register changes.
- R3: When `bus_ale` is pulsed high and then low, the address present while it was high is used for the access, and later changes on `bus_addr` are ignored until the next access.
- R4: With `bus_ale` held at 1, the address on `bus_addr` is used directly.
- R5: On a read, exactly 3 clock rising edges after `bus_rd_n` falls, `bus_rdy_n` goes to 0, `bus_doe` goes to 1, and `bus_dout` holds the addressed register.
- R6: On a write, the register at the address takes `bus_din`, and `bus_rdy_n` goes to 0 exactly 3 clock rising edges after `bus_wr_n` falls.
- R7: Once the active strobe or chip select is seen high, `bus_rdy_n` returns to 1 and `bus_doe` to 0. Ready is 1 whenever no access is in progress.
- R8: A write commits once per low period of `bus_wr_n`: changing `bus_din` while the strobe stays low does not alter the register.
- R9: If read and write strobes are both low when either falls, no access is done and ready stays 1 until both are released.
- R10: With 16 registers (default), addresses 16 and above read back as 0x00 and ignore writes, with no aliasing onto low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 11 | Register address from the processor |
| bus_ale | input | 1 | Address latch enable, active high, capture on falling edge |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_din | input | 8 | Write data from the processor |
| bus_dout | output | 8 | Read data toward the pad driver |
| bus_doe | output | 1 | Output-enable for the data pad driver |
| bus_rdy_n | output | 1 | Ready acknowledge, active low |

## Verification
The assertions check on every cycle that ready is released whenever both synchronised strobes or chip select are inactive. They also check that the output-enable is never on without ready, that ready only falls after exactly one strobe was low, and that a register write is a single-cycle pulse followed by ready falling. Only the bench scenarios can show the values of the data: what each register holds after sweeps with a pulsed and a tied-high latch-enable, that a changed address after the latch-enable falls is ignored, that out-of-range writes do not alias, and that the three-clock acknowledge latency holds.

// File: rtl/regbus_pkg.sv
// Package: shared types for the strobe-handshake register bus slave.
// Assumes: nothing beyond the standard language.
package regbus_pkg;
    // Handshake sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FAULT = 2'd3
    } bus_state_t;

    // Bit positions inside the synchronised control vector.
    localparam int CTL_WR  = 0;
    localparam int CTL_RD  = 1;
    localparam int CTL_CS  = 2;
    localparam int CTL_ALE = 3;
    localparam int CTL_W   = 4;
endpackage

// File: rtl/regbus_sync.sv
// Module: multi-stage flop chain used both as a metastability synchroniser
// for single-bit controls and as a matching delay line for the address.
// Assumes: multi-bit inputs are stable around the controls that qualify them.
module regbus_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            // Later stages resolve metastability / add matching delay.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/regbus_addr_latch.sv
// Module: address capture. The raw address is delayed by the same number of
// stages as the latch-enable so both stay aligned; the held address follows
// the delayed bus while the synchronised enable is high and freezes on its fall.
// Assumes: the address is stable while the latch-enable is high and settles
// at least STAGES clocks before it falls.
module regbus_addr_latch #(
    parameter int ADDR_W = 11,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_raw,
    input  logic              ale_s,
    output logic [ADDR_W-1:0] addr_q
);
    logic [ADDR_W-1:0] addr_dly;

    regbus_sync #(
        .WIDTH  (ADDR_W),
        .STAGES (STAGES),
        .RST_VAL('0)
    ) u_addr_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (addr_raw),
        .q    (addr_dly)
    );

    // Hold register: transparent while enable is high, frozen otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     addr_q <= '0;
        else if (ale_s) addr_q <= addr_dly;
    end
endmodule

// File: rtl/regbus_regfile.sv
// Module: small register array with one write port and one read port that
// share the latched address. Out-of-range addresses read as zero and drop
// writes.
// Assumes: NUM_REGS is at least 2 and not above 2**ADDR_W.
module regbus_regfile #(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

    logic [DATA_W-1:0] mem [NUM_REGS];
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign in_range = {1'b0, addr} < LIMIT;
    assign idx      = addr[IDX_W-1:0];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // One storage word: cleared on reset, loaded on an in-range write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (we && in_range && (idx == IDX_W'(i)))
                mem[i] <= wdata;
        end
    end

    // Read mux with zero fill outside the implemented range.
    always_comb begin
        rdata = '0;
        if (in_range) rdata = mem[idx];
    end
endmodule

// File: rtl/regbus_ctrl.sv
// Module: handshake sequencer. Detects strobe falling edges on synchronised,
// active-low controls, issues one register write per write-strobe low period,
// captures read data, and drives registered ready and output-enable.
// Assumes: inputs are already synchronised to clk.
module regbus_ctrl
    import regbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              rd_n_s,
    input  logic              wr_n_s,
    input  logic [DATA_W-1:0] rdata,
    output logic              reg_we,
    output logic [DATA_W-1:0] dout,
    output logic              doe,
    output logic              rdy_n
);
    bus_state_t state_q, state_d;
    logic       rd_n_d, wr_n_d;
    logic       rd_fall, wr_fall;

    // Previous strobe levels for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_n_d <= 1'b1;
            wr_n_d <= 1'b1;
        end else begin
            rd_n_d <= rd_n_s;
            wr_n_d <= wr_n_s;
        end
    end

    assign rd_fall = rd_n_d & ~rd_n_s;
    assign wr_fall = wr_n_d & ~wr_n_s;

    // Next-state decision and write pulse.
    always_comb begin
        state_d = state_q;
        reg_we  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_n_s && (rd_fall || wr_fall)) begin
                    if (!rd_n_s && !wr_n_s) begin
                        state_d = ST_FAULT;
                    end else if (rd_fall) begin
                        state_d = ST_READ;
                    end else begin
                        state_d = ST_WRITE;
                        reg_we  = 1'b1;
                    end
                end
            end
            ST_READ:  if (cs_n_s || rd_n_s)   state_d = ST_IDLE;
            ST_WRITE: if (cs_n_s || wr_n_s)   state_d = ST_IDLE;
            ST_FAULT: if (rd_n_s && wr_n_s)   state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // State register and registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdy_n   <= 1'b1;
            doe     <= 1'b0;
            dout    <= '0;
        end else begin
            state_q <= state_d;
            rdy_n   <= !((state_d == ST_READ) || (state_d == ST_WRITE));
            doe     <= (state_d == ST_READ);
            if ((state_q == ST_IDLE) && (state_d == ST_READ))
                dout <= rdata;
        end
    end
endmodule

// File: rtl/cpu_regbus_slave.sv
// Module: top of the asynchronous strobe-handshake register bus slave.
// Synchronises the bus controls, latches the address, and connects the
// sequencer to the register array.
// Assumes: write data is stable for the whole write-strobe low period; the
// data pad tristate is built outside from bus_dout and bus_doe.
module cpu_regbus_slave
    import regbus_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ale,
    input  logic              bus_cs_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              bus_rdy_n
);
    localparam logic [CTL_W-1:0] CTL_RST = 4'b0111;

    logic [CTL_W-1:0]  ctl_raw, ctl_s;
    logic              ale_s, cs_n_s, rd_n_s, wr_n_s;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] reg_rdata;
    logic              reg_we;

    // Pack the raw controls into one vector for the shared synchroniser.
    always_comb begin
        ctl_raw          = '0;
        ctl_raw[CTL_ALE] = bus_ale;
        ctl_raw[CTL_CS]  = bus_cs_n;
        ctl_raw[CTL_RD]  = bus_rd_n;
        ctl_raw[CTL_WR]  = bus_wr_n;
    end

    regbus_sync #(
        .WIDTH  (CTL_W),
        .STAGES (STAGES),
        .RST_VAL(CTL_RST)
    ) u_ctl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ctl_raw),
        .q    (ctl_s)
    );

    assign ale_s  = ctl_s[CTL_ALE];
    assign cs_n_s = ctl_s[CTL_CS];
    assign rd_n_s = ctl_s[CTL_RD];
    assign wr_n_s = ctl_s[CTL_WR];

    regbus_addr_latch #(
        .ADDR_W(ADDR_W),
        .STAGES(STAGES)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_raw(bus_addr),
        .ale_s   (ale_s),
        .addr_q  (reg_addr)
    );

    regbus_regfile #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (reg_addr),
        .we   (reg_we),
        .wdata(bus_din),
        .rdata(reg_rdata)
    );

    regbus_ctrl #(
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n_s(cs_n_s),
        .rd_n_s(rd_n_s),
        .wr_n_s(wr_n_s),
        .rdata (reg_rdata),
        .reg_we(reg_we),
        .dout  (bus_dout),
        .doe   (bus_doe),
        .rdy_n (bus_rdy_n)
    );
endmodule

// File: rtl/regbus_chk.sv
// Module: protocol checker for cpu_regbus_slave, attached by bind.
// Assumes: it observes the synchronised controls and the write pulse.
module regbus_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_s,
    input logic rd_n_s,
    input logic wr_n_s,
    input logic reg_we,
    input logic bus_doe,
    input logic bus_rdy_n
);
    // R7: both strobes inactive releases ready on the next cycle.
    a_r7_release_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n_s && wr_n_s) |=> bus_rdy_n);

    // R2: chip select inactive means ready is high on the next cycle.
    a_r2_cs_gates_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> bus_rdy_n);

    // R5: data driver only enabled while ready is asserted.
    a_r5_doe_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> !bus_rdy_n);

    // R9: ready only falls after exactly one strobe was low.
    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rdy_n) |-> $past(rd_n_s != wr_n_s));

    // R8: the write pulse lasts a single cycle.
    a_r8_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R6: a commit is acknowledged on the following cycle.
    a_r6_ack_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> $fell(bus_rdy_n));
endmodule

bind cpu_regbus_slave regbus_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_s   (cs_n_s),
    .rd_n_s   (rd_n_s),
    .wr_n_s   (wr_n_s),
    .reg_we   (reg_we),
    .bus_doe  (bus_doe),
    .bus_rdy_n(bus_rdy_n)
);

// File: tb/sim_cpu_regbus_slave.sv
module sim_cpu_regbus_slave;
    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 16;
    localparam int SPAN       = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_ale = 1'b0;
    logic        bus_cs_n = 1'b1;
    logic        bus_rd_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic [7:0]  bus_din = '0;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic        bus_rdy_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_regbus_slave u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_ale(bus_ale),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_rdy_n(bus_rdy_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37 + 5) & 8'hFF);
    endfunction

    function automatic logic [7:0] expect_rd(input int a);
        if (a < NREG) return model[a];
        return 8'h00;
    endfunction

    // One full bus access; a_late replaces the address after the ALE pulse.
    task automatic access(input bit is_wr, input logic [10:0] a,
                          input logic [10:0] a_late, input logic [7:0] d,
                          input bit pulse_ale, output logic [7:0] rd_val,
                          output int lat, output bit doe_seen);
        int rel;
        @(negedge clk);
        bus_cs_n = 1'b0;
        bus_addr = a;
        if (pulse_ale) begin
            bus_ale = 1'b1;
            repeat (3) @(negedge clk);
            bus_ale = 1'b0;
            repeat (3) @(negedge clk);
            bus_addr = a_late;
        end else begin
            bus_ale = 1'b1;
            repeat (4) @(negedge clk);
        end
        bus_din = d;
        if (is_wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
        lat = 0;
        while (bus_rdy_n && lat < 12) begin
            @(negedge clk);
            lat++;
        end
        rd_val   = bus_dout;
        doe_seen = bus_doe;
        bus_wr_n = 1'b1;
        bus_rd_n = 1'b1;
        rel = 0;
        while (!bus_rdy_n && rel < 12) begin
            @(negedge clk);
            rel++;
        end
        chk(bus_rdy_n && !bus_doe && rel <= 4, "R7 release", rel, 3);
        bus_cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(input int a, input logic [7:0] d, input bit pulse);
        logic [7:0] v; int lat; bit oe;
        access(1'b1, 11'(a), 11'(a), d, pulse, v, lat, oe);
        chk(lat == 3, "R6 write ack latency", lat, 3);
        chk(!oe, "R6 no drive on write", int'(oe), 0);
        if (a < NREG) model[a] = d;
    endtask

    task automatic do_read(input int a, input bit pulse, input string req);
        logic [7:0] v; int lat; bit oe;
        access(1'b0, 11'(a), 11'(a), 8'h00, pulse, v, lat, oe);
        chk(lat == 3, "R5 read ack latency", lat, 3);
        chk(oe, "R5 drive enabled", int'(oe), 1);
        chk(v == expect_rd(a), req, int'(v), int'(expect_rd(a)));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v; int lat; bit oe;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        chk(bus_rdy_n == 1'b1, "R1 ready idle in reset", int'(bus_rdy_n), 1);
        chk(bus_doe == 1'b0, "R1 doe low in reset", int'(bus_doe), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_rdy_n == 1'b1, "R1 ready after reset", int'(bus_rdy_n), 1);
        for (int a = 0; a < NREG; a += 5) do_read(a, 1'b1, "R1 reset contents");

        // Sweep writes: even addresses pulse ALE (R3), odd hold it high (R4).
        for (int a = 0; a < SPAN; a++) do_write(a, pattern(a), (a % 2) == 0);
        for (int a = 0; a < SPAN; a++)
            do_read(a, (a % 2) == 1, a < NREG ? "R3/R4 readback" : "R10 out of range zero");

        // R10: high address and aliasing address.
        do_write(11'h7FF, 8'hC3, 1'b1);
        do_read(11'h7FF, 1'b0, "R10 top address zero");
        do_write(NREG, 8'h77, 1'b0);
        do_read(0, 1'b0, "R10 no alias to 0");

        // R3: address changed after ALE falls is ignored.
        access(1'b1, 11'd6, 11'd9, 8'h3C, 1'b1, v, lat, oe);
        model[6] = 8'h3C;
        do_read(6, 1'b1, "R3 latched address written");
        do_read(9, 1'b1, "R3 later address untouched");
        access(1'b0, 11'd9, 11'd6, 8'h00, 1'b1, v, lat, oe);
        chk(v == model[9], "R3 latched address read", int'(v), int'(model[9]));

        // R8: hold write strobe low and change data after commit.
        @(negedge clk);
        bus_cs_n = 1'b0; bus_ale = 1'b1; bus_addr = 11'd3;
        repeat (4) @(negedge clk);
        bus_din = 8'hA5; bus_wr_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(bus_rdy_n == 1'b0, "R6 ready held low", int'(bus_rdy_n), 0);
        bus_din = 8'h5A;
        repeat (20) @(negedge clk);
        chk(bus_rdy_n == 1'b0, "R8 ready stays low while strobe low", int'(bus_rdy_n), 0);
        bus_wr_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(bus_rdy_n == 1'b1, "R7 ready released", int'(bus_rdy_n), 1);
        bus_cs_n = 1'b1;
        model[3] = 8'hA5;
        repeat (3) @(negedge clk);
        do_read(3, 1'b0, "R8 single commit");

        // R9: both strobes together.
        @(negedge clk);
        bus_cs_n = 1'b0; bus_ale = 1'b1; bus_addr = 11'd4; bus_din = 8'hEE;
        repeat (4) @(negedge clk);
        bus_rd_n = 1'b0; bus_wr_n = 1'b0;
        repeat (8) @(negedge clk);
        chk(bus_rdy_n == 1'b1, "R9 no ack on dual strobe", int'(bus_rdy_n), 1);
        chk(bus_doe == 1'b0, "R9 no drive on dual strobe", int'(bus_doe), 0);
        bus_rd_n = 1'b1; bus_wr_n = 1'b1; bus_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        do_read(4, 1'b0, "R9 register unchanged");

        // R2: strobe with chip select inactive.
        @(negedge clk);
        bus_cs_n = 1'b1; bus_ale = 1'b1; bus_addr = 11'd5; bus_din = 8'h11;
        repeat (4) @(negedge clk);
        bus_wr_n = 1'b0;
        repeat (8) @(negedge clk);
        chk(bus_rdy_n == 1'b1, "R2 no ack without select", int'(bus_rdy_n), 1);
        bus_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        do_read(5, 1'b0, "R2 register unchanged");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule